// File: doc/BRIEF.md
# Transmit Byte Queue with Saturating Free-Space Field

This block is the 64-byte transmit queue between a serial host port and a radio transmit datapath. The host side can only write into it, one byte per write pulse. The transmit datapath drains it one byte per read pulse. The host never reads the queue. What the host gets back instead is a 4-bit free-space field that travels in the status byte shifted out during every transfer.

The free-space field is captured at the start of each byte on the serial port. It therefore describes the space that was free before the byte now being shifted in. When 15 or more bytes are free, the field saturates at 15. The field holds its value for the whole byte, so it stays steady while its bits are shifted out.

Draining an empty queue while the transmitter is active sets a sticky underflow flag. The state machine reports that flag as its underflow state. A flush command is honoured only while the radio is idle or the underflow flag is set. Entering sleep empties the queue unconditionally. A write to a full queue is discarded and sets a sticky overflow flag.

Top module: `tx_fifo_status`

## Requirements
- R1: After reset the queue is empty: `fill_level` = 0, `empty` = 1, `full` = 0, `free_field` = 15, and both `underflow` and `overflow` are 0.
- R2: Bytes written with `wr_en` come out in the order they were written. A `rd_en` on a non-empty queue presents the oldest byte on `rd_data` with `rd_valid` = 1 in the following cycle.
- R3: On each `byte_start` pulse, `free_field` is loaded in the next cycle with min(64 − `fill_level`, 15), using the level before the byte now in progress. The field holds that value until the next pulse. With 63 bytes stored the field reads 1, with 50 stored it reads 14, with 49 stored it reads 15, and with 64 stored it reads 0.
- R4: A write while `full` = 1 leaves the contents and `fill_level` unchanged and sets `overflow`. `overflow` stays set until an accepted flush.
- R5: A `rd_en` on an empty queue while `tx_active` = 1 sets the sticky `underflow` flag. The same read with `tx_active` = 0 leaves `underflow` at 0.
- R6: A `flush` pulse while `in_idle` = 1 or `underflow` = 1 empties the queue and clears both `underflow` and `overflow` in the next cycle.
- R7: A `flush` pulse while `in_idle` = 0 and `underflow` = 0 is ignored: `fill_level` and the stored contents are kept.
- R8: A `sleep` pulse empties the queue in every state and leaves `underflow` and `overflow` unchanged.
- R9: `full` is 1 exactly when 64 bytes are stored. `fill_level` counts the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_start | input | 1 | Pulse at the start of each serial byte; captures the free-space field |
| wr_en | input | 1 | Store `wr_data` |
| wr_data | input | 8 | Byte from the host port |
| rd_en | input | 1 | Drain one byte to the transmit datapath |
| rd_data | output | 8 | Drained byte |
| rd_valid | output | 1 | `rd_data` holds a byte drained in the previous cycle |
| tx_active | input | 1 | Transmitter is running |
| in_idle | input | 1 | Radio is in the idle state |
| flush | input | 1 | Flush command pulse |
| sleep | input | 1 | Entry into sleep, empties the queue |
| free_field | output | 4 | Saturated free-byte count for the status byte |
| fill_level | output | 7 | Number of stored bytes |
| full | output | 1 | 64 bytes stored |
| empty | output | 1 | No bytes stored |
| underflow | output | 1 | Sticky underflow flag |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The assertions assume single-cycle pulses on `byte_start`, `flush` and `sleep`. They assume `in_idle` and `tx_active` change only between operations, and the flush and sleep properties exclude cycles in which another command arrives together with them. The directed stimulus respects this. It raises one control at a time, keeps the mode inputs steady around each command, and never issues `byte_start` in the same cycle as a write, so the captured field always reflects a settled level.

// File: rtl/tx_fifo_status.sv
module tx_fifo_status #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int FW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_start,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_valid,
  input  logic                       tx_active,
  input  logic                       in_idle,
  input  logic                       flush,
  input  logic                       sleep,
  output logic [FW-1:0]              free_field,
  output logic [$clog2(DEPTH):0]     fill_level,
  output logic                       full,
  output logic                       empty,
  output logic                       underflow,
  output logic                       overflow
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int FMAX = (1 << FW) - 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, free_cnt;
  logic          flush_ok, clear, do_wr, do_rd;
  logic [FW-1:0] free_sat;

  assign fill_level = wptr - rptr;
  assign empty      = (wptr == rptr);
  assign full       = (fill_level == PW'(DEPTH));
  assign flush_ok   = flush && (in_idle || underflow);
  assign clear      = sleep || flush_ok;
  assign do_wr      = wr_en && !full && !clear;
  assign do_rd      = rd_en && !empty && !clear;
  assign free_cnt   = PW'(DEPTH) - fill_level;
  assign free_sat   = (free_cnt > PW'(FMAX)) ? FW'(FMAX) : free_cnt[FW-1:0];

  always_ff @(posedge clk)
    if (do_wr) mem[wptr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clear) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= mem[rptr[AW-1:0]];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else if (flush_ok) begin
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else if (!sleep) begin
      if (rd_en && empty && tx_active) underflow <= 1'b1;
      if (wr_en && full) overflow <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) free_field <= FW'(FMAX);
    else if (byte_start) free_field <= free_sat;
endmodule

// File: rtl/tx_fifo_status_chk.sv
module tx_fifo_status_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int FW    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   byte_start,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic                   rd_valid,
  input logic                   tx_active,
  input logic                   in_idle,
  input logic                   flush,
  input logic                   sleep,
  input logic [FW-1:0]          free_field,
  input logic [$clog2(DEPTH):0] fill_level,
  input logic                   full,
  input logic                   empty,
  input logic                   underflow,
  input logic                   overflow
);
  localparam int AW   = $clog2(DEPTH);
  localparam int FMAX = (1 << FW) - 1;

  function automatic logic [FW-1:0] expect_free(input logic [AW:0] lvl);
    int f;
    f = DEPTH - int'(lvl);
    return (f > FMAX) ? FW'(FMAX) : FW'(f);
  endfunction

  a_r3_field_capture: assert property (@(posedge clk) disable iff (!rst_n)
    byte_start |=> free_field == expect_free($past(fill_level)));

  a_r3_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_start |=> $stable(free_field));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en && !sleep && !flush) |=> (full && overflow));

  a_r5_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && tx_active && !sleep && !flush) |=> underflow);

  a_r2_empty_read_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> !rd_valid);

  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && (in_idle || underflow)) |=> (empty && !underflow && !overflow));

  a_r7_flush_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !in_idle && !underflow && !sleep && !wr_en && !rd_en) |=> $stable(fill_level));

  a_r8_sleep_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !flush) |=> (empty && underflow == $past(underflow) && overflow == $past(overflow)));

  a_r9_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (fill_level == (AW+1)'(DEPTH) && !empty));
endmodule

bind tx_fifo_status tx_fifo_status_chk #(.DEPTH(DEPTH), .DW(DW), .FW(FW)) u_chk (.*);

// File: tb/tx_fifo_status_test.sv
`timescale 1ns/1ps
module tx_fifo_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_start = 0, wr_en = 0, rd_en = 0, tx_active = 0, in_idle = 1, flush = 0, sleep = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       rd_valid, full, empty, underflow, overflow;
  logic [3:0] free_field;
  logic [6:0] fill_level;
  int vectors = 0, errors = 0;

  tx_fifo_status uut (.*);

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7) ^ 8'h5A;
  endfunction

  task automatic put(input logic [7:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic take(output logic [7:0] d, output logic v);
    rd_en = 1; tick(); rd_en = 0; d = rd_data; v = rd_valid;
  endtask

  task automatic pulse_status();
    byte_start = 1; tick(); byte_start = 0;
  endtask

  task automatic do_flush();
    flush = 1; tick(); flush = 0;
  endtask

  task automatic t_reset();
    chk("R1 level", fill_level, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 field", free_field, 15);
    chk("R1 underflow", underflow, 0);
    chk("R1 overflow", overflow, 0);
  endtask

  task automatic t_order();
    logic [7:0] d; logic v;
    for (int i = 0; i < 5; i++) put(pat(i));
    chk("R9 level 5", fill_level, 5);
    pulse_status();
    chk("R3 field at 5 stored", free_field, 15);
    for (int i = 0; i < 5; i++) begin
      take(d, v);
      chk("R2 valid", v, 1);
      chk("R2 order", d, pat(i));
    end
    chk("R2 drained", empty, 1);
    tick();
    chk("R2 valid drops", rd_valid, 0);
  endtask

  task automatic t_status_fill();
    for (int k = 0; k < 63; k++) begin
      put(pat(k));
      if (k + 1 == 49) begin pulse_status(); chk("R3 field at 49", free_field, 15); end
      if (k + 1 == 50) begin pulse_status(); chk("R3 field at 50", free_field, 14); end
    end
    pulse_status();
    chk("R3 field before last byte", free_field, 1);
    put(8'hC3);
    chk("R3 field held", free_field, 1);
    chk("R9 full", full, 1);
    chk("R9 level 64", fill_level, 64);
    pulse_status();
    chk("R3 field at full", free_field, 0);
  endtask

  task automatic t_overflow();
    logic [7:0] d; logic v;
    put(8'hEE);
    chk("R4 level kept", fill_level, 64);
    chk("R4 overflow set", overflow, 1);
    take(d, v);
    chk("R4 head intact", d, pat(0));
    tick();
    chk("R4 overflow sticky", overflow, 1);
  endtask

  task automatic t_flush_ignored();
    logic [7:0] d; logic v;
    in_idle = 0; tx_active = 1; tick();
    do_flush();
    chk("R7 level kept", fill_level, 63);
    chk("R7 overflow kept", overflow, 1);
    take(d, v);
    chk("R7 contents kept", d, pat(1));
  endtask

  task automatic t_flush_idle();
    tx_active = 0; in_idle = 1; tick();
    do_flush();
    chk("R6 idle flush empty", empty, 1);
    chk("R6 idle flush overflow", overflow, 0);
  endtask

  task automatic t_underflow();
    logic [7:0] d; logic v;
    in_idle = 0; tx_active = 0; tick();
    take(d, v);
    chk("R5 no underflow when not sending", underflow, 0);
    tx_active = 1; tick();
    take(d, v);
    chk("R5 underflow set", underflow, 1);
    chk("R2 empty read invalid", v, 0);
    put(8'h11); put(8'h22);
    tx_active = 0; tick();
    do_flush();
    chk("R6 underflow flush empty", empty, 1);
    chk("R6 underflow cleared", underflow, 0);
  endtask

  task automatic t_sleep();
    logic [7:0] d; logic v;
    in_idle = 0; tx_active = 1; tick();
    take(d, v);
    chk("R5 setup underflow", underflow, 1);
    put(8'h33); put(8'h44); put(8'h55);
    chk("R9 level 3", fill_level, 3);
    sleep = 1; tick(); sleep = 0;
    chk("R8 sleep empties", fill_level, 0);
    chk("R8 underflow kept", underflow, 1);
    tx_active = 0; in_idle = 1; tick();
    do_flush();
    chk("R6 final clear", underflow, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_order();
    t_status_fill();
    t_overflow();
    t_flush_ignored();
    t_flush_idle();
    t_underflow();
    t_sleep();
    summary();
    $finish;
  end
endmodule